// File: doc/BRIEF.md
# Open-Drain Response Frame Transmitter

This block sends a 16-slot response frame on a shared, wired bus line that any station may pull active. When a trigger arrives while the block is idle, it captures a car index, a 2-bit lane-change status and a sender identity. It packs them into a word and sets two framing positions to one. It then sends the word least-significant bit first. Each bit stays on the line for a fixed number of clock cycles.

The output is a driver enable rather than a line level. A one in a slot turns the open-drain pull-down driver on. A zero leaves the line released, so other stations and the pull-up decide its level. When the last slot ends, the enable always returns low so the bus is free again. A busy flag tells the surrounding logic when a frame is in progress. Triggers that arrive while the block is busy are dropped.

Top module: `resp_frame_tx`

## Requirements
- R1: After reset, `lineDrive_o` is 0 and `busy_o` is 0.
- R2: Slot 0 and slot 14 of every frame always enable the driver. Slot 15 always releases it.
- R3: A frame has 16 slots, sent in order from word bit 0 to word bit 15. Each slot lasts exactly `BIT_CYCLES` clock cycles, and `lineDrive_o` does not change inside a slot.
- R4: Slots 1 to 3 carry `carIdx_i`, with bit 0 of the car index in slot 1.
- R5: Slots 4 and 5 carry `laneStat_i`, with bit 0 of the status in slot 4.
- R6: Slots 6 to 9 carry `senderId_i`, with bit 0 of the identity in slot 6. Slots 10 to 13 always release the driver.
- R7: A word bit of 1 sets `lineDrive_o` to 1 (driver on). A word bit of 0 sets it to 0 (line released).
- R8: After the final slot, `lineDrive_o` is 0 and `busy_o` is 0. This holds from clock 16*`BIT_CYCLES`+1 after the trigger edge onward.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The frame in progress continues unchanged and no extra frame follows.
- R10: `busy_o` rises on the clock edge that samples an accepted trigger. It stays high for exactly 16*`BIT_CYCLES` cycles. The first slot appears on `lineDrive_o` at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Trigger strobe; accepted only when idle |
| carIdx_i | input | 3 | Car index placed in slots 1-3 |
| laneStat_i | input | 2 | Lane-change status placed in slots 4-5 |
| senderId_i | input | 4 | Sender identity placed in slots 6-9 |
| lineDrive_o | output | 1 | Open-drain driver enable (1 = pull line active) |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The assertions assume that `start_i` and the frame fields are stable around the clock edge that samples them. They also assume the field inputs matter only on the accepting edge, so later changes must not reach the line. The bench drives all inputs at the falling clock edge. It changes the field values, and pulses the trigger with different values, while a frame is under way. This shows that only the captured word reaches the line. Frames are started again in the first idle cycle, which tests the boundary where release and a new start meet.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;
  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;   // capture composed word, present slot 0
    logic shift;  // advance to the next slot
    logic clear;  // final slot done, release the line
  } tx_strobe_t;
endpackage

// File: rtl/resp_tx_ctrl.sv
module resp_tx_ctrl
  import resp_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 49,
  parameter int FRAME_W    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output tx_strobe_t strobes_o,
  output logic       busy_o
);
  localparam int CNT_W  = $clog2(BIT_CYCLES + 1);
  localparam int SLOT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(BIT_CYCLES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_W - 1);

  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t            stateQ, stateD;
  logic [CNT_W-1:0]  cycCntQ, cycCntD;
  logic [SLOT_W-1:0] slotCntQ, slotCntD;
  tx_strobe_t        strobes;

  always_comb begin
    stateD   = stateQ;
    cycCntD  = cycCntQ;
    slotCntD = slotCntQ;
    strobes  = '0;
    case (stateQ)
      ST_IDLE: begin
        if (start_i) begin
          strobes.load = 1'b1;
          stateD       = ST_SEND;
          cycCntD      = '0;
          slotCntD     = '0;
        end
      end
      ST_SEND: begin
        if (cycCntQ == CNT_LAST) begin
          cycCntD = '0;
          if (slotCntQ == SLOT_LAST) begin
            strobes.clear = 1'b1;
            stateD        = ST_IDLE;
          end else begin
            strobes.shift = 1'b1;
            slotCntD      = slotCntQ + 1'b1;
          end
        end else begin
          cycCntD = cycCntQ + 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      cycCntQ  <= '0;
      slotCntQ <= '0;
    end else begin
      stateQ   <= stateD;
      cycCntQ  <= cycCntD;
      slotCntQ <= slotCntD;
    end
  end

  assign strobes_o = strobes;
  assign busy_o    = (stateQ == ST_SEND);

  // R9: a word is captured only from idle, never mid-frame
  assert_load_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |-> !busy_o);
  // R10: an accepted trigger raises busy on the next edge
  assert_busy_after_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> busy_o);
  // R8: finishing the last slot drops busy
  assert_idle_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> !busy_o);
  // R3: at most one strobe per cycle
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.load, strobes.shift, strobes.clear}));
endmodule

// File: rtl/resp_tx_datapath.sv
module resp_tx_datapath
  import resp_tx_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int CAR_W    = 3,
  parameter int STAT_W   = 2,
  parameter int SENDER_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tx_strobe_t          strobes_i,
  input  logic [CAR_W-1:0]    carIdx_i,
  input  logic [STAT_W-1:0]   laneStat_i,
  input  logic [SENDER_W-1:0] senderId_i,
  output logic                lineDrive_o
);
  localparam int START_POS  = 0;
  localparam int CAR_LSB    = 1;
  localparam int STAT_LSB   = CAR_LSB + CAR_W;
  localparam int SENDER_LSB = STAT_LSB + STAT_W;
  localparam int STOP_POS   = FRAME_W - 2;

  logic [FRAME_W-1:0] word;
  logic [FRAME_W-1:0] shiftQ;
  logic               driveQ;

  // Compose the frame word; framing positions forced to one
  always_comb begin
    word                          = '0;
    word[CAR_LSB +: CAR_W]        = carIdx_i;
    word[STAT_LSB +: STAT_W]      = laneStat_i;
    word[SENDER_LSB +: SENDER_W]  = senderId_i;
    word[START_POS]               = 1'b1;
    word[STOP_POS]                = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftQ <= '0;
      driveQ <= 1'b0;
    end else if (strobes_i.load) begin
      driveQ <= word[0];
      shiftQ <= word >> 1;
    end else if (strobes_i.shift) begin
      driveQ <= shiftQ[0];
      shiftQ <= shiftQ >> 1;
    end else if (strobes_i.clear) begin
      driveQ <= 1'b0;
      shiftQ <= '0;
    end
  end

  assign lineDrive_o = driveQ;

  // R2: the first slot of each frame is the forced start bit
  assert_first_slot_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes_i.load) |-> driveQ);
  // R8: the line is released once the frame is over
  assert_release_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes_i.clear) |-> !driveQ);
  // R3: the drive level only moves on a strobe
  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobes_i.load | strobes_i.shift | strobes_i.clear) |-> $stable(driveQ));
endmodule

// File: rtl/resp_frame_tx.sv
module resp_frame_tx
  import resp_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 49,
  parameter int FRAME_W    = 16,
  parameter int CAR_W      = 3,
  parameter int STAT_W     = 2,
  parameter int SENDER_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CAR_W-1:0]    carIdx_i,
  input  logic [STAT_W-1:0]   laneStat_i,
  input  logic [SENDER_W-1:0] senderId_i,
  output logic                lineDrive_o,
  output logic                busy_o
);
  tx_strobe_t strobes;

  resp_tx_ctrl #(
    .BIT_CYCLES (BIT_CYCLES),
    .FRAME_W    (FRAME_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .strobes_o (strobes),
    .busy_o    (busy_o)
  );

  resp_tx_datapath #(
    .FRAME_W  (FRAME_W),
    .CAR_W    (CAR_W),
    .STAT_W   (STAT_W),
    .SENDER_W (SENDER_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes_i   (strobes),
    .carIdx_i    (carIdx_i),
    .laneStat_i  (laneStat_i),
    .senderId_i  (senderId_i),
    .lineDrive_o (lineDrive_o)
  );
endmodule

// File: tb/resp_frame_tx_bench.sv
module resp_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] carIdx_i = '0;
  logic [1:0] laneStat_i = '0;
  logic [3:0] senderId_i = '0;
  logic       lineDrive_o;
  logic       busy_o;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;
  logic [15:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_frame_tx #(.BIT_CYCLES(HOLD)) u_resp_frame_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .carIdx_i(carIdx_i),
    .laneStat_i(laneStat_i), .senderId_i(senderId_i),
    .lineDrive_o(lineDrive_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string slotTag(input int s);
    if (s == 0 || s == 14 || s == 15) return "R2 framing slot";
    if (s <= 3) return "R4 car slot";
    if (s <= 5) return "R5 status slot";
    return "R6 sender/zero slot";
  endfunction

  // Driver: start a frame at the first idle cycle and push its expected word
  task automatic sendFrame(input logic [2:0] car, input logic [1:0] st, input logic [3:0] id);
    logic [15:0] w;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    w = '0; w[0] = 1'b1; w[3:1] = car; w[5:4] = st; w[9:6] = id; w[14] = 1'b1;
    carIdx_i = car; laneStat_i = st; senderId_i = id; start_i = 1'b1;
    expQ.push_back(w);
    @(negedge clk);
    start_i = 1'b0;
    carIdx_i = ~car; laneStat_i = ~st; senderId_i = ~id; // later changes must not matter
  endtask

  // R9: pulse a trigger with other values mid-frame; nothing pushed
  task automatic pokeBusy(input int waitCycles);
    repeat (waitCycles) @(negedge clk);
    carIdx_i = 3'b010; laneStat_i = 2'b10; senderId_i = 4'b0101; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor: pop one expected word per frame, compare every cycle of every slot
  initial begin
    logic [15:0] exp;
    forever begin
      @(negedge clk);
      if (rst_n && busy_o) begin
        if (expQ.size() == 0) begin
          check(0, "R9 unexpected frame", 1, 0);
          exp = '0;
        end else exp = expQ.pop_front();
        for (int s = 0; s < 16; s++) begin
          bit bad = 0;
          int act = lineDrive_o;
          for (int c = 0; c < HOLD; c++) begin
            if (s != 0 || c != 0) @(negedge clk);
            if (lineDrive_o !== exp[s] || busy_o !== 1'b1) begin
              bad = 1; act = lineDrive_o;
            end
          end
          // R3/R7/R10: slot s holds word bit s for HOLD cycles while busy
          check(!bad, slotTag(s), act, exp[s]);
        end
        @(negedge clk);
        check(lineDrive_o === 1'b0 && busy_o === 1'b0, "R8 release after frame",
              {busy_o, lineDrive_o}, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lineDrive_o === 1'b0, "R1 drive after reset", lineDrive_o, 0);
    check(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(lineDrive_o === 1'b0 && busy_o === 1'b0, "R1 idle after release", {busy_o, lineDrive_o}, 0);

    sendFrame(3'd0, 2'd0, 4'd0);      // only framing bits
    sendFrame(3'd7, 2'd3, 4'd15);     // all fields set
    sendFrame(3'd5, 2'd1, 4'd10);
    pokeBusy(20);                     // R9 ignored trigger
    sendFrame(3'd2, 2'd2, 4'd5);
    pokeBusy(3);
    pokeBusy(40);
    sendFrame(3'd1, 2'd1, 4'd1);      // back-to-back start at first idle cycle

    @(negedge clk);
    while (busy_o || expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(busy_o === 1'b0 && lineDrive_o === 1'b0, "R9 no extra frame", {busy_o, lineDrive_o}, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule